// File: doc/BRIEF.md
# Rate-1/3 Parallel Turbo Encoder

This block turns one code block of K bits into a rate-1/3 turbo codeword. The bits arrive one per beat on a valid/ready input stream and are written into an internal bit buffer. Once all K bits are held, the block emits one beat per codeword position on a valid/ready output stream. Each beat carries three bits: the systematic bit, the parity bit from a recursive systematic encoder that reads the block in natural order, and the parity bit from an identical encoder that reads it in a quadratic-permutation order. Four termination beats follow the K data beats. They carry the tail bits that return both encoders to the all-zero state.

The block length K and the permutation coefficients f1 and f2 are plain configuration inputs. They must stay constant from the first input beat of a block until its done pulse, and both coefficients must be smaller than K. The input side applies back-pressure by holding in_ready low for the whole output phase. The output side accepts back-pressure on any beat. While out_ready is low, the current beat is held unchanged. A one-cycle done pulse closes each codeword, and the block is then ready to load the next one.

Top module: `tc_turbo_enc`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0 and done is 0.
- R2: in_ready and out_valid are never high together. in_ready stays high until K input beats have been accepted, and it stays low from then until the done pulse.
- R3: On data beat i (0 <= i < K), out_sys equals the i-th accepted input bit.
- R4: On data beat i, out_par1 is the output of a recursive encoder with 3 memory cells, feedback taps 1+D^2+D^3 and output taps 1+D+D^3, started from the zero state and fed the block in natural order.
- R5: out_par2 comes from an identical encoder fed with bit pi(i) on beat i, where pi(i) = (f1*i + f2*i*i) mod K.
- R6: Each encoder produces three tail steps. Its input on each step is its own feedback value, giving tail pairs (x0,z0), (x1,z1), (x2,z2). The four termination beats carry these tail bits as {sys,par1,par2}. Beat K carries encoder 1 (x0,z0,x1). Beat K+1 carries encoder 1 (z1,x2,z2). Beats K+2 and K+3 carry the same pattern for encoder 2.
- R7: Both encoders are at the zero state when done is raised, so the next block is encoded from the zero state.
- R8: While out_valid is 1 and out_ready is 0, out_valid stays 1 on the next cycle and every output data bit and flag is unchanged.
- R9: out_tail is 1 on exactly the four termination beats. out_last is 1 only on the final one, beat K+3, so a codeword has exactly K+4 beats.
- R10: done is a single-cycle pulse in the cycle after the handshake of the final beat. Loading of the next block is possible from that cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_k | input | KW | Block length K (1..KMAX) |
| cfg_f1 | input | KW | Linear permutation coefficient, less than K |
| cfg_f2 | input | KW | Quadratic permutation coefficient, less than K |
| in_valid | input | 1 | Input bit valid |
| in_ready | output | 1 | Buffer accepts an input bit |
| in_bit | input | 1 | Code block bit |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_sys | output | 1 | Systematic stream bit |
| out_par1 | output | 1 | Natural-order parity bit |
| out_par2 | output | 1 | Permuted-order parity bit |
| out_tail | output | 1 | Beat is a termination beat |
| out_last | output | 1 | Final beat of the codeword |
| done | output | 1 | Codeword complete pulse |

## Verification
The hardest case to reach from the ports is a stall that falls on a termination beat while the encoder states are frozen, followed directly by a new block that depends on those states having been cleared. The stimulus drives out_ready from a repeating pattern that is low on one cycle in three, so stalls land on data, tail and last beats across blocks of different lengths. Blocks are sent back to back with no reset in between. Every parity bit of each later block is compared against a reference model that starts from the zero state, with the permutation computed directly from its formula.

// File: rtl/tc_pkg.sv
package tc_pkg;

  typedef enum logic [1:0] {
    PH_LOAD = 2'd0,
    PH_DATA = 2'd1,
    PH_TAIL = 2'd2
  } phase_t;

  // Tail bits of a constituent encoder whose input equals its own feedback.
  // s[0] is the newest cell. Result bits: 0=x0 1=z0 2=x1 3=z1 4=x2 5=z2.
  function automatic logic [5:0] tail_bits(input logic [2:0] s);
    logic [5:0] t;
    t[0] = s[1] ^ s[2];
    t[1] = s[0] ^ s[2];
    t[2] = s[0] ^ s[1];
    t[3] = s[1];
    t[4] = s[0];
    t[5] = s[0];
    return t;
  endfunction

endpackage

// File: rtl/tc_bitbuf.sv
module tc_bitbuf #(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_bit,
  input  logic [AW-1:0] rd_addr_a,
  input  logic [AW-1:0] rd_addr_b,
  output logic          rd_a,
  output logic          rd_b
);
  logic [DEPTH-1:0] mem;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_bit;
  end

  assign rd_a = mem[rd_addr_a];
  assign rd_b = mem[rd_addr_b];
endmodule

// File: rtl/tc_qpp_addr.sv
module tc_qpp_addr #(
  parameter int KW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init,
  input  logic          adv,
  input  logic [KW-1:0] k,
  input  logic [KW-1:0] f1,
  input  logic [KW-1:0] f2,
  output logic [KW-1:0] addr
);
  logic [KW-1:0] gap;

  // (a + b) mod m, both operands already below m
  function automatic logic [KW-1:0] madd(input logic [KW-1:0] a,
                                         input logic [KW-1:0] b,
                                         input logic [KW-1:0] m);
    logic [KW:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= {1'b0, m}) s = s - {1'b0, m};
    return s[KW-1:0];
  endfunction

  logic [KW-1:0] gap_inc;
  assign gap_inc = madd(f2, f2, k);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr <= '0;
      gap  <= '0;
    end else if (init) begin
      addr <= '0;
      gap  <= madd(f1, f2, k);
    end else if (adv) begin
      addr <= madd(addr, gap, k);
      gap  <= madd(gap, gap_inc, k);
    end
  end
endmodule

// File: rtl/tc_rsc_enc.sv
module tc_rsc_enc (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       clear,
  input  logic       din,
  output logic       par,
  output logic [2:0] st
);
  logic fb;

  assign fb  = din ^ st[1] ^ st[2];
  assign par = fb ^ st[0] ^ st[2];

  always_ff @(posedge clk) begin
    if (!rst_n)     st <= '0;
    else if (clear) st <= '0;
    else if (step)  st <= {st[1], st[0], fb};
  end
endmodule

// File: rtl/tc_turbo_enc.sv
module tc_turbo_enc
  import tc_pkg::*;
#(
  parameter int KMAX = 1024,
  localparam int KW = $clog2(KMAX + 1),
  localparam int AW = $clog2(KMAX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [KW-1:0] cfg_k,
  input  logic [KW-1:0] cfg_f1,
  input  logic [KW-1:0] cfg_f2,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_bit,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_sys,
  output logic          out_par1,
  output logic          out_par2,
  output logic          out_tail,
  output logic          out_last,
  output logic          done
);
  phase_t        ph;
  logic [KW-1:0] cnt;
  logic [1:0]    tcnt;
  logic [KW-1:0] il_addr;
  logic          wr, fire, fire_data, fire_end, at_end;
  logic          sys_bit, il_bit;
  logic [1:0]       enc_din, enc_par;
  logic [1:0][2:0]  enc_st;
  logic [1:0][5:0]  tail;

  assign in_ready  = (ph == PH_LOAD);
  assign out_valid = (ph != PH_LOAD);
  assign wr        = in_valid && in_ready;
  assign fire      = out_valid && out_ready;
  assign at_end    = (cnt == cfg_k - KW'(1));
  assign fire_data = fire && (ph == PH_DATA);
  assign fire_end  = fire && (ph == PH_TAIL) && (tcnt == 2'd3);

  tc_bitbuf #(.DEPTH(KMAX)) u_buf (
    .clk       (clk),
    .wr_en     (wr),
    .wr_addr   (cnt[AW-1:0]),
    .wr_bit    (in_bit),
    .rd_addr_a (cnt[AW-1:0]),
    .rd_addr_b (il_addr[AW-1:0]),
    .rd_a      (sys_bit),
    .rd_b      (il_bit)
  );

  tc_qpp_addr #(.KW(KW)) u_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .init  (wr && at_end),
    .adv   (fire_data),
    .k     (cfg_k),
    .f1    (cfg_f1),
    .f2    (cfg_f2),
    .addr  (il_addr)
  );

  assign enc_din = {il_bit, sys_bit};

  for (genvar g = 0; g < 2; g++) begin : g_enc
    tc_rsc_enc u_enc (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (fire_data),
      .clear (fire_end),
      .din   (enc_din[g]),
      .par   (enc_par[g]),
      .st    (enc_st[g])
    );
    assign tail[g] = tail_bits(enc_st[g]);
  end

  always_comb begin
    out_sys  = 1'b0;
    out_par1 = 1'b0;
    out_par2 = 1'b0;
    if (ph == PH_DATA) begin
      out_sys  = sys_bit;
      out_par1 = enc_par[0];
      out_par2 = enc_par[1];
    end else if (ph == PH_TAIL) begin
      if (tcnt[0] == 1'b0) begin
        out_sys  = tail[tcnt[1]][0];
        out_par1 = tail[tcnt[1]][1];
        out_par2 = tail[tcnt[1]][2];
      end else begin
        out_sys  = tail[tcnt[1]][3];
        out_par1 = tail[tcnt[1]][4];
        out_par2 = tail[tcnt[1]][5];
      end
    end
  end

  assign out_tail = (ph == PH_TAIL);
  assign out_last = (ph == PH_TAIL) && (tcnt == 2'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph   <= PH_LOAD;
      cnt  <= '0;
      tcnt <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (ph)
        PH_LOAD: if (wr) begin
          if (at_end) begin
            cnt <= '0;
            ph  <= PH_DATA;
          end else begin
            cnt <= cnt + KW'(1);
          end
        end
        PH_DATA: if (fire) begin
          if (at_end) begin
            cnt  <= '0;
            tcnt <= '0;
            ph   <= PH_TAIL;
          end else begin
            cnt <= cnt + KW'(1);
          end
        end
        PH_TAIL: if (fire) begin
          if (tcnt == 2'd3) begin
            ph   <= PH_LOAD;
            done <= 1'b1;
          end
          tcnt <= tcnt + 2'd1;
        end
        default: ph <= PH_LOAD;
      endcase
    end
  end
endmodule

// File: rtl/tc_turbo_enc_chk.sv
module tc_turbo_enc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic       out_sys,
  input logic       out_par1,
  input logic       out_par2,
  input logic       out_tail,
  input logic       out_last,
  input logic       done,
  input logic [2:0] st_a,
  input logic [2:0] st_b
);
  logic [2:0] tail_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) tail_seen <= '0;
    else if (out_valid && out_ready && out_last) tail_seen <= '0;
    else if (out_valid && out_ready && out_tail) tail_seen <= tail_seen + 3'd1;
  end

  // R2
  load_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid &&
      $stable({out_sys, out_par1, out_par2, out_tail, out_last})));

  // R9
  last_in_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> out_tail);

  // R9
  tail_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |-> (tail_seen == 3'd3));

  // R10
  done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> done);

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  zero_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (st_a == 3'd0 && st_b == 3'd0));
endmodule

bind tc_turbo_enc tc_turbo_enc_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_sys   (out_sys),
  .out_par1  (out_par1),
  .out_par2  (out_par2),
  .out_tail  (out_tail),
  .out_last  (out_last),
  .done      (done),
  .st_a      (enc_st[0]),
  .st_b      (enc_st[1])
);

// File: tb/tc_turbo_enc_bench.sv
`timescale 1ns/100ps
module tc_turbo_enc_bench;
  localparam int KMAX = 1024;
  localparam int KW = $clog2(KMAX + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [KW-1:0] cfg_k = '0, cfg_f1 = '0, cfg_f2 = '0;
  logic in_valid = 1'b0, in_bit = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid, out_sys, out_par1, out_par2, out_tail, out_last, done;

  int checks = 0;
  int errors = 0;

  logic dat [0:KMAX-1];
  logic e0 [0:KMAX+3];
  logic e1 [0:KMAX+3];
  logic e2 [0:KMAX+3];

  always #2 clk = ~clk;

  tc_turbo_enc #(.KMAX(KMAX)) u_tc_turbo_enc (
    .clk(clk), .rst_n(rst_n), .cfg_k(cfg_k), .cfg_f1(cfg_f1), .cfg_f2(cfg_f2),
    .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit),
    .out_valid(out_valid), .out_ready(out_ready), .out_sys(out_sys),
    .out_par1(out_par1), .out_par2(out_par2), .out_tail(out_tail),
    .out_last(out_last), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fill(input int k, input int pat);
    int h = 37;
    for (int i = 0; i < k; i++) begin
      h = (h * 1103 + 12345) % 65521;
      case (pat)
        0: dat[i] = (i % 2) == 0;
        1: dat[i] = 1'b0;
        2: dat[i] = 1'b1;
        default: dat[i] = h[4];
      endcase
    end
  endtask

  // Reference model of R3..R6 from the requirement text
  task automatic model(input int k, input int f1, input int f2);
    logic s1, s2, s3, x, a;
    logic tx [0:1][0:2];
    logic tz [0:1][0:2];
    for (int e = 0; e < 2; e++) begin
      s1 = 0; s2 = 0; s3 = 0;
      for (int i = 0; i < k; i++) begin
        longint p = (longint'(f1) * i + longint'(f2) * i * i) % k;
        x = (e == 0) ? dat[i] : dat[int'(p)];
        a = x ^ s2 ^ s3;
        if (e == 0) e1[i] = a ^ s1 ^ s3; else e2[i] = a ^ s1 ^ s3;
        s3 = s2; s2 = s1; s1 = a;
      end
      for (int t = 0; t < 3; t++) begin
        x = s2 ^ s3;
        a = x ^ s2 ^ s3;
        tx[e][t] = x;
        tz[e][t] = a ^ s1 ^ s3;
        s3 = s2; s2 = s1; s1 = a;
      end
    end
    for (int i = 0; i < k; i++) e0[i] = dat[i];
    for (int e = 0; e < 2; e++) begin
      e0[k+2*e] = tx[e][0]; e1[k+2*e] = tz[e][0]; e2[k+2*e] = tx[e][1];
      e0[k+2*e+1] = tz[e][1]; e1[k+2*e+1] = tx[e][2]; e2[k+2*e+1] = tz[e][2];
    end
  endtask

  task automatic run_block(input string name, input int k, input int f1, input int f2,
                           input int pat, input bit stall);
    int i = 0, c = 0, beat = 0, ov_bad = 0, ir_bad = 0, hold_bad = 0;
    int sys_bad = 0, p1_bad = 0, p2_bad = 0, tail_bad = 0, flag_bad = 0;
    logic hv = 0;
    logic [4:0] hold = '0;
    fill(k, pat);
    model(k, f1, f2);
    cfg_k = KW'(k); cfg_f1 = KW'(f1); cfg_f2 = KW'(f2);
    while (i < k) begin
      @(negedge clk);
      c++;
      in_valid = stall ? ((c % 4) != 2) : 1'b1;
      in_bit = dat[i];
      #1;
      if (out_valid) ov_bad++;
      if (in_valid && in_ready) i++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    c = 0;
    while (beat < k + 4 && c < 20000) begin
      if (c > 0) @(negedge clk);
      c++;
      if (hv && ({out_sys, out_par1, out_par2, out_tail, out_last} !== hold)) hold_bad++;
      out_ready = stall ? ((c % 3) != 1) : 1'b1;
      #1;
      if (in_ready) ir_bad++;
      hv = 0;
      if (out_valid && out_ready) begin
        if (beat < k) begin
          if (out_sys !== e0[beat]) sys_bad++;
          if (out_par1 !== e1[beat]) p1_bad++;
          if (out_par2 !== e2[beat]) p2_bad++;
          if (out_tail !== 1'b0 || out_last !== 1'b0) flag_bad++;
        end else begin
          if ({out_sys, out_par1, out_par2} !== {e0[beat], e1[beat], e2[beat]}) tail_bad++;
          if (out_tail !== 1'b1 || out_last !== (beat == k + 3)) flag_bad++;
        end
        beat++;
      end else if (out_valid) begin
        hv = 1;
        hold = {out_sys, out_par1, out_par2, out_tail, out_last};
      end
    end
    check(beat == k + 4, {name, " R9 beat count"}, beat, k + 4);
    check(ov_bad == 0 && ir_bad == 0, {name, " R2 in_ready/out_valid exclusive"}, ov_bad + ir_bad, 0);
    check(sys_bad == 0, {name, " R3 systematic mismatches"}, sys_bad, 0);
    check(p1_bad == 0, {name, " R4 parity1 mismatches"}, p1_bad, 0);
    check(p2_bad == 0, {name, " R5 parity2 mismatches"}, p2_bad, 0);
    check(tail_bad == 0, {name, " R6 R7 termination mismatches"}, tail_bad, 0);
    check(flag_bad == 0, {name, " R9 tail/last flags"}, flag_bad, 0);
    if (stall) check(hold_bad == 0, {name, " R8 stalled beat changed"}, hold_bad, 0);
    @(negedge clk);
    out_ready = 1'b0;
    #1;
    check(done === 1'b1, {name, " R10 done after final beat"}, int'(done), 1);
    @(negedge clk);
    #1;
    check(done === 1'b0 && in_ready === 1'b1 && out_valid === 1'b0,
          {name, " R10 single done, ready to load"}, int'({done, in_ready, out_valid}), 2);
  endtask

  task automatic t_reset;
    #1;
    check(in_ready === 1'b1 && out_valid === 1'b0 && done === 1'b0,
          "R1 reset state", int'({in_ready, out_valid, done}), 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    run_block("alt40", 40, 3, 10, 0, 1'b0);
    run_block("rnd48", 48, 7, 12, 3, 1'b1);
    run_block("zero40", 40, 3, 10, 1, 1'b0);
    run_block("ones64", 64, 7, 16, 2, 1'b1);
    run_block("tiny8", 8, 3, 2, 3, 1'b1);
    run_block("rnd1008", 1008, 55, 84, 3, 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule